// File: doc/BRIEF.md
# Modem Line Change Detector

This block monitors the four modem handshake inputs of a serial port: clear-to-send, data-set-ready, ring indicator and carrier detect. It brings each input into the system clock domain and records every relevant change in a sticky change flag. Each flag remains set until the host reads the modem status byte. The byte holds the current line levels in its upper nibble and the change flags in its lower nibble. The interrupt output is high while any flag is set, provided the enable input allows it. This is the lowest-priority interrupt source of the port, and its identification code is 0000. The priority encoder that uses that code is outside this block.

The ring indicator records only a low-to-high transition. The other three lines record a change in either direction. A host read strobe clears all four flags on the clock edge where it is high. A change detected on that same edge overrides the clear, so no event is lost. Each flag is a small two-state machine. FLG_IDLE moves to FLG_PEND on a qualifying edge (transition EV_SET). FLG_PEND moves back to FLG_IDLE on a read with no coinciding edge (transition RD_CLR). FLG_PEND stays in FLG_PEND on a read that coincides with an edge, or when no read occurs (transition HOLD).

Top module: `modem_delta_watch`

## Requirements
- R1: After reset, `msr_q` is 8'h00 and `irq` is 0, provided all line inputs are low.
- R2: Bits 7:4 of `msr_q` show the synchronized levels of DCD (bit 7), RI (bit 6), DSR (bit 5) and CTS (bit 4). A level applied just after clock edge n appears just after edge n+2.
- R3: A change in either direction on CTS, DSR or DCD sets bit 0, 1 or 3 respectively, one clock edge after the new level appears in the upper nibble.
- R4: A low-to-high transition of RI sets bit 2 with the same timing as R3. A high-to-low transition of RI sets no flag.
- R5: A set flag stays set across any number of cycles without a read.
- R6: When `msr_rd` is high at a clock edge and no change is detected on that edge, all four flags are 0 after that edge.
- R7: A change detected on the same edge as a read leaves that line's flag set after the edge. The other flags are cleared.
- R8: `irq` equals `irq_en` AND (any of bits 3:0). Flags are recorded whether or not the interrupt is enabled.
- R9: Several changes on one line between reads leave a single set flag, and one read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| ri_in | input | 1 | Ring indicator line, asynchronous |
| dcd_in | input | 1 | Carrier detect line, asynchronous |
| msr_rd | input | 1 | Host read strobe for the status byte; clears the flags |
| irq_en | input | 1 | Modem interrupt enable |
| msr_q | output | 8 | Status byte: levels in 7:4, change flags in 3:0 |
| irq | output | 1 | Modem status interrupt request |

## Verification
A flag machine stuck in FLG_IDLE shows as a missing bit in the low nibble, three edges after the line moves. A machine that misses RD_CLR shows as a bit still set on the first cycle after a read. A wrong edge mode on the ring line shows as a flag after a falling ring edge. A lost HOLD on a coinciding read shows as a cleared bit right after that read, even though the upper nibble has just changed. A broken synchronizer chain shows as a level bit one cycle early or late.

// File: rtl/md_pkg.sv
package md_pkg;

    localparam int unsigned LINE_CNT = 4;

    // line positions inside the status byte
    localparam int unsigned LN_CTS = 0;
    localparam int unsigned LN_DSR = 1;
    localparam int unsigned LN_RI  = 2;
    localparam int unsigned LN_DCD = 3;

    typedef enum logic {
        EDGE_ANY  = 1'b0,
        EDGE_RISE = 1'b1
    } edge_mode_e;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;

endpackage

// File: rtl/md_sync.sv
module md_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/md_flag_fsm.sv
module md_flag_fsm
    import md_pkg::*;
#(
    parameter edge_mode_e MODE = EDGE_ANY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic clr,
    output logic flag
);

    flag_state_e state_q, state_d;
    logic        lvl_prev_q;
    logic        hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_prev_q <= 1'b0;
        else        lvl_prev_q <= lvl;
    end

    generate
        if (MODE == EDGE_RISE) begin : g_rise
            assign hit = lvl & ~lvl_prev_q;
        end else begin : g_any
            assign hit = lvl ^ lvl_prev_q;
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    // transitions: EV_SET, RD_CLR, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (hit)       state_d = FLG_PEND;
            FLG_PEND: if (clr && !hit) state_d = FLG_IDLE;
            default:                 state_d = FLG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            FLG_PEND: flag = 1'b1;
            default:  flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/modem_delta_watch.sv
module modem_delta_watch
    import md_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_in,
    input  logic       dsr_in,
    input  logic       ri_in,
    input  logic       dcd_in,
    input  logic       msr_rd,
    input  logic       irq_en,
    output logic [7:0] msr_q,
    output logic       irq
);

    localparam int unsigned W = LINE_CNT;

    logic [W-1:0] raw;
    logic [W-1:0] lvl;
    logic [W-1:0] flg;

    always_comb begin
        raw         = '0;
        raw[LN_CTS] = cts_in;
        raw[LN_DSR] = dsr_in;
        raw[LN_RI]  = ri_in;
        raw[LN_DCD] = dcd_in;
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_line
            localparam edge_mode_e LMODE = (i == LN_RI) ? EDGE_RISE : EDGE_ANY;

            md_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .d_in   (raw[i]),
                .d_sync (lvl[i])
            );

            md_flag_fsm #(.MODE(LMODE)) u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .lvl   (lvl[i]),
                .clr   (msr_rd),
                .flag  (flg[i])
            );
        end
    endgenerate

    assign msr_q = {lvl, flg};
    assign irq   = irq_en & (|flg);

endmodule

// File: rtl/modem_delta_watch_chk.sv
module modem_delta_watch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       msr_rd,
    input logic       irq_en,
    input logic [7:0] msr_q,
    input logic       irq
);

    // R3
    cts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msr_q[0]) |-> ($past(msr_q[4]) != $past(msr_q[4], 2)));

    // R4
    ri_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msr_q[2]) |-> ($past(msr_q[6]) && !$past(msr_q[6], 2)));

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msr_rd |=> (($past(msr_q[3:0]) & ~msr_q[3:0]) == 4'b0));

    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && msr_q[7:4] == $past(msr_q[7:4])) |=> (msr_q[3:0] == 4'b0));

    // R7
    no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && msr_q[4] != $past(msr_q[4])) |=> msr_q[0]);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (msr_q[3:0] != 4'b0));

endmodule

bind modem_delta_watch modem_delta_watch_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .msr_rd (msr_rd),
    .irq_en (irq_en),
    .msr_q  (msr_q),
    .irq    (irq)
);

// File: tb/modem_delta_watch_bench.sv
module modem_delta_watch_bench;

    typedef struct {
        logic [7:0] msr;
        logic       irq;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_in = 1'b0, dsr_in = 1'b0, ri_in = 1'b0, dcd_in = 1'b0;
    logic       msr_rd = 1'b0;
    logic       irq_en = 1'b1;
    logic [7:0] msr_q;
    logic       irq;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    modem_delta_watch u_modem_delta_watch (
        .clk(clk), .rst_n(rst_n),
        .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in), .dcd_in(dcd_in),
        .msr_rd(msr_rd), .irq_en(irq_en), .msr_q(msr_q), .irq(irq)
    );

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (msr_q !== e.msr || irq !== e.irq) begin
                n_bad++;
                $display("FAIL %s: msr_q=%h irq=%b expected msr_q=%h irq=%b",
                         e.tag, msr_q, irq, e.msr, e.irq);
            end
        end
    end

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_out(logic [7:0] m, logic i, string tag);
        exp_t e;
        e.msr = m; e.irq = i; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic do_read();
        msr_rd = 1'b1;
        tick();
        msr_rd = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        expect_out(8'h00, 1'b0, "R1 reset state");

        cts_in = 1'b1; tick(2);
        expect_out(8'h10, 1'b0, "R2 level after sync");
        tick();
        expect_out(8'h11, 1'b1, "R3 cts rise flag");
        tick(3);
        expect_out(8'h11, 1'b1, "R5 flag held");
        do_read();
        expect_out(8'h10, 1'b0, "R6 read clears");

        ri_in = 1'b1; tick(3);
        expect_out(8'h54, 1'b1, "R4 ri rising flag");
        do_read();
        expect_out(8'h50, 1'b0, "R6 read clears ri");
        ri_in = 1'b0; tick(3);
        expect_out(8'h10, 1'b0, "R4 ri falling ignored");
        tick(2);
        expect_out(8'h10, 1'b0, "R4 ri falling still ignored");

        dsr_in = 1'b1; dcd_in = 1'b1; tick(3);
        expect_out(8'hBA, 1'b1, "R3 dsr and dcd flags");

        cts_in = 1'b0; tick(2);
        msr_rd = 1'b1; tick(); msr_rd = 1'b0;
        expect_out(8'hA1, 1'b1, "R7 change kept on read edge");
        do_read();
        expect_out(8'hA0, 1'b0, "R6 second read clears");

        irq_en = 1'b0; dcd_in = 1'b0; tick(3);
        expect_out(8'h28, 1'b0, "R8 flag recorded with irq masked");
        irq_en = 1'b1;
        expect_out(8'h28, 1'b1, "R8 irq after enable");
        do_read();
        expect_out(8'h20, 1'b0, "R6 clear dcd flag");

        cts_in = 1'b1; tick(); cts_in = 1'b0; tick(3);
        expect_out(8'h21, 1'b1, "R9 pulse leaves single flag");
        do_read();
        expect_out(8'h20, 1'b0, "R9 one read clears");

        tick(2);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule